// File: doc/BRIEF.md
# Event-Reloaded Watchdog Countdown Timer

This block is a host-programmable watchdog. A host writes an 8-bit reload value and picks seconds or minutes as the unit. The timer then counts down once per unit tick. When the count reaches zero it stops and latches a time-out flag. That flag can drive an interrupt request and a watchdog output whose active level is programmable.

Three single-cycle system-event pulses can each be enabled to restart the countdown from the stored value: a keyboard interrupt, a mouse interrupt, and an already decoded access to the game-port address. A restart also clears the flag. A reload value of zero disables the timer. A self-clearing force bit makes the timer expire at once.

The block derives the one-second tick from the clock with a parameterised prescaler. A further divider, which can be shortened for simulation, derives the minute tick. Any reload restarts both dividers, so the time to expiry is exact.

Top module: `wdt_event_timer`

## Requirements
- R1: After synchronous reset, all registers read 0, the flag is clear, `irq` is 0 and `wdo` is 1 (active-low by default).
- R2: While the value register (address 1) holds 0, the flag never sets by itself, and event pulses have no effect.
- R3: Writing a non-zero N to address 1 with the units bit clear sets the flag exactly N*CLKS_PER_SEC cycles after the write edge.
- R4: With bit 7 of address 0 set (minute units), the flag sets exactly N*SEC_PER_MIN*CLKS_PER_SEC cycles after the write edge.
- R5: After expiry the count stays at zero, so clearing the flag does not lead to another expiry.
- R6: A write to address 2 loads bit 0 into the flag directly, in any timer state.
- R7: Address 3 holds the event enables: bit 0 keyboard, bit 1 mouse, bit 2 game port. An enabled event restarts the countdown from the value register and clears the flag. A disabled event changes nothing.
- R8: Writing address 2 with bit 2 set makes the flag 1 after that edge and zeroes the count. Bit 2 always reads back as 0.
- R9: `irq` equals the flag when address 3 bit 3 is set, and is 0 otherwise.
- R10: `wdo` is high when the flag is set if address 3 bit 4 is 1, and low when the flag is set if that bit is 0. In both cases it is inverted while the flag is clear.
- R11: If a value write and an enabled event fall in the same cycle, the write wins: the new value is loaded and the flag is not cleared.
- R12: If a force write and an enabled event fall in the same cycle, the force wins.
- R13: Reads: address 0 returns the units bit in bit 7, address 1 the value, address 2 the flag in bit 0, and address 3 the five configuration bits. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (also selects read data) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| kbd_evt | input | 1 | Keyboard interrupt pulse |
| mouse_evt | input | 1 | Mouse interrupt pulse |
| joy_evt | input | 1 | Decoded game-port access pulse |
| irq | output | 1 | Interrupt request |
| wdo | output | 1 | Watchdog output, programmable polarity |

## Verification
Register writes, force and event pulses all take effect at the first clock edge after they are presented. The flag, `irq` and `wdo` therefore change right after that edge, and read data follows combinationally. A countdown started at edge E sets the flag exactly at edge E+T, where T is the value times the tick length. The bench drives all inputs on the falling edge. It samples the flag one cycle before E+T, where it must still be clear, and again just after E+T, where it must be set. Register readback is sampled after a short delay within the falling-edge half cycle, without advancing the clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ADR_UNITS = 2'd0,
        ADR_VALUE = 2'd1,
        ADR_CTRL  = 2'd2,
        ADR_CFG   = 2'd3
    } wdt_addr_e;

    localparam int NUM_EVT  = 3;
    localparam int VAL_W    = 8;

    // Configuration register layout: kbd_en is bit 0, pol is bit 4
    typedef struct packed {
        logic pol;
        logic irq_en;
        logic joy_en;
        logic mouse_en;
        logic kbd_en;
    } wdt_cfg_t;

    typedef struct packed {
        logic             force_to;
        logic             value_wr;
        logic [VAL_W-1:0] value;
        logic             status_wr;
        logic             status_val;
    } wdt_cmd_t;

    function automatic wdt_cfg_t cfg_from_byte(input logic [7:0] b);
        wdt_cfg_t c;
        c.kbd_en   = b[0];
        c.mouse_en = b[1];
        c.joy_en   = b[2];
        c.irq_en   = b[3];
        c.pol      = b[4];
        return c;
    endfunction

    function automatic wdt_cmd_t decode_cmd(input logic we, input logic [1:0] a,
                                            input logic [7:0] d);
        wdt_cmd_t c;
        c.force_to   = we && (wdt_addr_e'(a) == ADR_CTRL) && d[2];
        c.value_wr   = we && (wdt_addr_e'(a) == ADR_VALUE);
        c.value      = d;
        c.status_wr  = we && (wdt_addr_e'(a) == ADR_CTRL);
        c.status_val = d[0];
        return c;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CLKS_PER_SEC = 32768,
    parameter int SEC_PER_MIN  = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic sec_tick,
    output logic min_tick
);
    localparam int CNT_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_SEC - 1);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    logic [CNT_W-1:0] clk_cnt;
    logic [SEC_W-1:0] sec_cnt;

    assign sec_tick = (clk_cnt == CNT_LAST);
    assign min_tick = sec_tick && (sec_cnt == SEC_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            clk_cnt <= '0;
            sec_cnt <= '0;
        end else begin
            if (sec_tick) begin
                clk_cnt <= '0;
                if (sec_cnt == SEC_LAST) sec_cnt <= '0;
                else                     sec_cnt <= sec_cnt + 1'b1;
            end else begin
                clk_cnt <= clk_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_event_gate.sv
module wdt_event_gate #(
    parameter int N = 3
) (
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    output logic         hit
);
    logic [N-1:0] masked;
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = evt[i] & en[i];
    end
    assign hit = |masked;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             status,
    output logic [7:0]       rdata,
    output logic             units_min,
    output logic [VAL_W-1:0] value,
    output wdt_cfg_t         cfg,
    output wdt_cmd_t         cmd
);
    assign cmd = decode_cmd(wr_en, addr, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            units_min <= 1'b0;
            value     <= '0;
            cfg       <= '0;
        end else if (wr_en) begin
            unique case (wdt_addr_e'(addr))
                ADR_UNITS: units_min <= wdata[7];
                ADR_VALUE: value     <= wdata;
                ADR_CFG:   cfg       <= cfg_from_byte(wdata);
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (wdt_addr_e'(addr))
            ADR_UNITS: rdata = {units_min, 7'd0};
            ADR_VALUE: rdata = value;
            ADR_CTRL:  rdata = {7'd0, status};
            default:   rdata = {3'd0, cfg};
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             evt_hit,
    input  logic [VAL_W-1:0] value,
    input  wdt_cmd_t         cmd,
    output logic             restart,
    output logic [VAL_W-1:0] count,
    output logic             status
);
    logic evt_ok;
    logic expire;

    // Host writes and force take priority over an event in the same cycle
    assign evt_ok  = evt_hit && (value != '0) && !cmd.value_wr && !cmd.force_to;
    assign restart = cmd.force_to || cmd.value_wr || evt_ok;
    assign expire  = tick && (count == VAL_W'(1)) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            status <= 1'b0;
        end else begin
            if (cmd.force_to)              count <= '0;
            else if (cmd.value_wr)         count <= cmd.value;
            else if (evt_ok)               count <= value;
            else if (tick && count != '0)  count <= count - 1'b1;

            if (cmd.force_to)              status <= 1'b1;
            else if (cmd.status_wr)        status <= cmd.status_val;
            else if (evt_ok)               status <= 1'b0;
            else if (expire)               status <= 1'b1;
        end
    end
endmodule

// File: rtl/wdt_event_timer.sv
module wdt_event_timer
    import wdt_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768,
    parameter int SEC_PER_MIN  = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       kbd_evt,
    input  logic       mouse_evt,
    input  logic       joy_evt,
    output logic       irq,
    output logic       wdo
);
    logic             units_min;
    logic [VAL_W-1:0] value_q;
    wdt_cfg_t         cfg_q;
    wdt_cmd_t         cmd;
    logic             status_q;
    logic [VAL_W-1:0] count_q;
    logic             restart;
    logic             sec_tick, min_tick, unit_tick;
    logic             evt_hit;

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .status(status_q), .rdata(rdata), .units_min(units_min),
        .value(value_q), .cfg(cfg_q), .cmd(cmd)
    );

    wdt_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
        .clk(clk), .rst(rst), .restart(restart),
        .sec_tick(sec_tick), .min_tick(min_tick)
    );

    assign unit_tick = units_min ? min_tick : sec_tick;

    wdt_event_gate #(.N(NUM_EVT)) u_gate (
        .evt({joy_evt, mouse_evt, kbd_evt}),
        .en ({cfg_q.joy_en, cfg_q.mouse_en, cfg_q.kbd_en}),
        .hit(evt_hit)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst(rst), .tick(unit_tick), .evt_hit(evt_hit),
        .value(value_q), .cmd(cmd), .restart(restart),
        .count(count_q), .status(status_q)
    );

    assign irq = status_q & cfg_q.irq_en;
    assign wdo = cfg_q.pol ? status_q : ~status_q;
endmodule

// File: rtl/wdt_event_timer_chk.sv
module wdt_event_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       kbd_evt,
    input logic       mouse_evt,
    input logic       joy_evt,
    input logic       irq,
    input logic       status,
    input logic [7:0] count,
    input logic [7:0] value,
    input logic [4:0] cfg_bits
);
    // R8: force write sets the flag and zeroes the count
    p_force_sets_status_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2 && wdata[2]) |=> (status && count == 8'd0));

    // R2: disabled timer keeps the flag unless the host writes
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (value == 8'd0 && !wr_en) |=> $stable(status));

    // R7: enabled keyboard event restarts and clears the flag
    p_event_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (kbd_evt && cfg_bits[0] && value != 8'd0 && !wr_en) |=> (!status && count == $past(value)));

    // R5: expired count stays at zero without reload stimulus
    p_halt_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (count == 8'd0 && !wr_en && !kbd_evt && !mouse_evt && !joy_evt) |=> count == 8'd0);

    // R11: a value write never changes the flag
    p_value_write_keeps_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1) |=> (status == $past(status) && count == $past(wdata)));

    // R9: interrupt only rises with the flag set
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status && cfg_bits[3]));
endmodule

bind wdt_event_timer wdt_event_timer_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .joy_evt(joy_evt),
    .irq(irq), .status(status_q), .count(count_q), .value(value_q),
    .cfg_bits(cfg_q)
);

// File: tb/wdt_event_timer_tb.sv
module wdt_event_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPS = 4;
    localparam int SPM = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       kbd_evt = 1'b0, mouse_evt = 1'b0, joy_evt = 1'b0;
    logic       irq, wdo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_event_timer #(.CLKS_PER_SEC(CPS), .SEC_PER_MIN(SPM)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .kbd_evt(kbd_evt), .mouse_evt(mouse_evt),
        .joy_evt(joy_evt), .irq(irq), .wdo(wdo)
    );

    function automatic int expiry_cycles(input int n, input bit minutes);
        return n * CPS * (minutes ? SPM : 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] e);
        {joy_evt, mouse_evt, kbd_evt} = e;
        @(negedge clk);
        {joy_evt, mouse_evt, kbd_evt} = 3'b000;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic flag(output int f);
        logic [7:0] d;
        rd(2'd2, d);
        f = d[0];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_expiry(input string req, input int t);
        int f;
        idle(t - 1);
        flag(f); chk(req, f, 0);
        idle(1);
        flag(f); chk(req, f, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int f;
        void'($urandom(32'd1234));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d); chk("R1 readback", d, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 wdo", wdo, 1);

        // R2 value 0 disables, events ignored
        bus_wr(2'd3, 8'h0F);
        idle(50);
        pulse(3'b111);
        flag(f); chk("R2 disabled", f, 0);

        // R3 seconds countdown, R9 irq, R10 active-low output
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'd5);
        expect_expiry("R3", expiry_cycles(5, 0));
        chk("R9 irq", irq, 1);
        chk("R10 wdo low", wdo, 0);

        // R5 halted at zero, R6 direct flag write
        bus_wr(2'd2, 8'h00);
        idle(40);
        flag(f); chk("R5 halt", f, 0);
        bus_wr(2'd2, 8'h01);
        flag(f); chk("R6 set", f, 1);
        bus_wr(2'd2, 8'h00);
        flag(f); chk("R6 clear", f, 0);

        // R7 each event restarts and clears
        bus_wr(2'd1, 8'd6);
        idle(10);
        pulse(3'b001);
        expect_expiry("R7 kbd reload", expiry_cycles(6, 0));
        pulse(3'b010);
        flag(f); chk("R7 mouse clears", f, 0);
        expect_expiry("R7 mouse reload", expiry_cycles(6, 0));
        pulse(3'b100);
        flag(f); chk("R7 joy clears", f, 0);
        bus_wr(2'd3, 8'h08);
        idle(expiry_cycles(6, 0) + 2);
        pulse(3'b111);
        flag(f); chk("R7 disabled ignored", f, 1);

        // R4 minute units, R13 readback
        bus_wr(2'd0, 8'h80);
        rd(2'd0, d); chk("R13 units", d, 8'h80);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'd3);
        expect_expiry("R4", expiry_cycles(3, 1));

        // R8 force
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'd10);
        idle(5);
        bus_wr(2'd2, 8'h04);
        rd(2'd2, d); chk("R8 force flag, bit2 reads 0", d, 8'h01);
        bus_wr(2'd2, 8'h00);
        idle(60);
        flag(f); chk("R8 count zeroed", f, 0);

        // R11 value write beats event
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd2, 8'h01);
        wr_en = 1'b1; addr = 2'd1; wdata = 8'd8; kbd_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; kbd_evt = 1'b0;
        flag(f); chk("R11 flag kept", f, 1);
        rd(2'd1, d); chk("R11 value", d, 8);
        bus_wr(2'd2, 8'h00);
        expect_expiry("R11 timing", expiry_cycles(8, 0) - 1);

        // R12 force beats event
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'd8);
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h04; mouse_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; mouse_evt = 1'b0;
        flag(f); chk("R12 force wins", f, 1);

        // R10 polarity, R9 irq masking, R13 cfg readback
        bus_wr(2'd3, 8'h1F);
        rd(2'd3, d); chk("R13 cfg", d, 8'h1F);
        chk("R10 wdo high", wdo, 1);
        bus_wr(2'd2, 8'h00);
        chk("R10 wdo idle", wdo, 0);
        chk("R9 irq clear", irq, 0);
        bus_wr(2'd3, 8'h17);
        bus_wr(2'd2, 8'h01);
        chk("R9 irq masked", irq, 0);
        chk("R10 wdo set", wdo, 1);

        // Random countdowns, R3 and R4
        bus_wr(2'd3, 8'h08);
        for (int i = 0; i < 8; i++) begin
            int v;
            bit m;
            v = 1 + int'($urandom % 7);
            m = bit'($urandom % 2);
            bus_wr(2'd0, {m, 7'd0});
            bus_wr(2'd2, 8'h00);
            bus_wr(2'd1, 8'(v));
            expect_expiry(m ? "R4 random" : "R3 random", expiry_cycles(v, m));
            chk("R9 random irq", irq, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule